// File: doc/BRIEF.md
# Two-Thread Group Completion Table

This block keeps track of instruction groups that have been dispatched but not yet retired, for a core that runs two hardware threads. Both threads share one table. Entries from the two threads sit mixed together, and each thread chains its own entries in dispatch order through a link field. A dispatch names the thread and the number of instructions in the group, which is one to five. The table answers in the same cycle with the index of the entry it will fill. Execution units identify each finished instruction by an entry index and a slot number, and may flag it as faulting.

Each thread has its own oldest-group pointer. When a thread's oldest group has every slot finished and no fault, the table asserts that thread's commit output and gives the entry index, and it frees the entry at the clock edge. The two threads retire independently, so two groups can leave in one cycle. A finished group that carries a fault is not retired. It raises a per-thread exception output and stays at the head of its thread until that thread is flushed. A flush removes every entry of one thread in a single cycle.

Top module: `gct_two_thread`

## Requirements
- R1: After reset, empty_o is 1, full_o is 0, disp_ready_o is 1, and commit_o and excp_o are all zero.
- R2: While disp_ready_o is high, disp_idx_o shows the lowest-numbered free entry. A dispatch with disp_valid_i high fills exactly that entry at the next clock edge.
- R3: full_o is high exactly when all DEPTH entries hold groups, and disp_ready_o is then low. A dispatch made while full is ignored. empty_o is high exactly when no entry holds a group.
- R4: A group of N instructions (disp_cnt_i = N, 1 to 5) waits only on slots 0 to N-1. Slots N to 4 count as finished from dispatch. A finish report (fin_entry_i, fin_slot_i in 0..4) to a free entry is ignored, so it cannot affect a group that is dispatched into that entry later.
- R5: commit_o[t] is high in the cycle after the last finish report of thread t's oldest group arrives, when no fault was reported. commit_idx_o slice t (bits t*IDXW upward) gives that entry, and the entry is free after the next edge.
- R6: A finished group never commits before an older group of the same thread. Groups of the other thread commit regardless of the order in which the two threads' groups were interleaved at dispatch.
- R7: Both threads can commit in the same cycle.
- R8: When a thread's oldest group is fully finished and any of its reports carried fin_exc_i, excp_o[t] is high and commit_o[t] stays low. Both hold until flush_i[t].
- R9: flush_i[t] frees every entry of thread t in one cycle. In that cycle it blocks a dispatch and a commit for thread t, and it leaves the other thread's entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| disp_valid_i | input | 1 | Dispatch a group this cycle |
| disp_tid_i | input | TIDW | Thread of the dispatched group |
| disp_cnt_i | input | CNTW | Instruction count of the group (1 to 5) |
| disp_ready_o | output | 1 | A free entry exists |
| disp_idx_o | output | IDXW | Entry that the dispatch fills |
| fin_valid_i | input | NFIN | Per finish port: report valid |
| fin_entry_i | input | NFIN*IDXW | Per finish port: entry index |
| fin_slot_i | input | NFIN*3 | Per finish port: slot within the group |
| fin_exc_i | input | NFIN | Per finish port: instruction faulted |
| flush_i | input | NTHR | Per thread: drop all of its groups |
| commit_o | output | NTHR | Per thread: oldest group retires this cycle |
| commit_idx_o | output | NTHR*IDXW | Per thread: entry index of the oldest group |
| excp_o | output | NTHR | Per thread: oldest group finished with a fault |
| full_o | output | 1 | Every entry is in use |
| empty_o | output | 1 | No entry is in use |

## Verification
The assertions assume that the execution units report only slots that exist in a live group, and that each instruction is reported at most once. They also assume that disp_cnt_i stays between 1 and 5. The bench keeps to these rules, with one planned exception: the case where finish reports aimed at free entries must be ignored. Dispatches are sent while the table is full, and during a flush of the same thread, to confirm they are dropped. Afterwards the bench reads back occupancy through empty_o, disp_idx_o and the commit outputs.

// File: rtl/gct_pkg.sv
package gct_pkg;
  localparam int GRP_MAX = 5;
  localparam int SLOT_W  = 3;
  localparam int CNT_W   = 3;

  typedef logic [GRP_MAX-1:0] fin_mask_t;

  // slots at or beyond the group size start out finished
  function automatic fin_mask_t slot_fill(logic [CNT_W-1:0] n);
    fin_mask_t m;
    for (int s = 0; s < GRP_MAX; s++) m[s] = (CNT_W'(s) >= n);
    return m;
  endfunction
endpackage

// File: rtl/gct_free_pick.sv
module gct_free_pick #(
  parameter int DEPTH = 16,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] vld_i,
  output logic [IDXW-1:0]  pick_o,
  output logic             full_o,
  output logic             empty_o
);
  always_comb begin
    pick_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_i[i]) pick_o = i[IDXW-1:0];
    end
  end

  assign full_o  = &vld_i;
  assign empty_o = ~|vld_i;
endmodule

// File: rtl/gct_thread_list.sv
module gct_thread_list #(
  parameter int DEPTH = 16,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            push_i,
  input  logic [IDXW-1:0] push_idx_i,
  input  logic            pop_i,
  input  logic [IDXW-1:0] head_next_i,
  output logic [IDXW-1:0] head_o,
  output logic [IDXW-1:0] tail_o,
  output logic            has_o
);
  logic [IDXW:0]   cnt_q;
  logic [IDXW-1:0] head_q, tail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
    end else if (flush_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + {{IDXW{1'b0}}, push_i} - {{IDXW{1'b0}}, pop_i};
      // new group becomes head if the list is or is about to be empty
      if (push_i && (cnt_q == '0 || (cnt_q == (IDXW+1)'(1) && pop_i)))
        head_q <= push_idx_i;
      else if (pop_i)
        head_q <= head_next_i;
      if (push_i) tail_q <= push_idx_i;
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign has_o  = (cnt_q != '0);

  assert_pop_nonempty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> has_o);
  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= (IDXW+1)'(DEPTH));
  assert_flush_drains_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !has_o);
endmodule

// File: rtl/gct_two_thread.sv
module gct_two_thread
  import gct_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NTHR  = 2,
  parameter int NFIN  = 2,
  localparam int IDXW = $clog2(DEPTH),
  localparam int TIDW = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int CNTW = CNT_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   disp_valid_i,
  input  logic [TIDW-1:0]        disp_tid_i,
  input  logic [CNTW-1:0]        disp_cnt_i,
  output logic                   disp_ready_o,
  output logic [IDXW-1:0]        disp_idx_o,
  input  logic [NFIN-1:0]        fin_valid_i,
  input  logic [NFIN*IDXW-1:0]   fin_entry_i,
  input  logic [NFIN*SLOT_W-1:0] fin_slot_i,
  input  logic [NFIN-1:0]        fin_exc_i,
  input  logic [NTHR-1:0]        flush_i,
  output logic [NTHR-1:0]        commit_o,
  output logic [NTHR*IDXW-1:0]   commit_idx_o,
  output logic [NTHR-1:0]        excp_o,
  output logic                   full_o,
  output logic                   empty_o
);
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] exc_q;
  logic [TIDW-1:0]  tid_q  [DEPTH];
  fin_mask_t        fin_q  [DEPTH];
  logic [IDXW-1:0]  link_q [DEPTH];

  logic [IDXW-1:0] pick;
  logic            full;
  logic [NTHR-1:0] disp_go, commit_go, has;
  logic [IDXW-1:0] head_w [NTHR];
  logic [IDXW-1:0] tail_w [NTHR];
  logic            link_we;
  logic [IDXW-1:0] link_at;

  gct_free_pick #(.DEPTH(DEPTH)) u_pick (
    .vld_i  (vld_q),
    .pick_o (pick),
    .full_o (full),
    .empty_o(empty_o)
  );

  assign full_o       = full;
  assign disp_ready_o = !full;
  assign disp_idx_o   = pick;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic hd_done;

    assign disp_go[t] = disp_valid_i && !full && (disp_tid_i == TIDW'(t)) && !flush_i[t];

    gct_thread_list #(.DEPTH(DEPTH)) u_list (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .flush_i    (flush_i[t]),
      .push_i     (disp_go[t]),
      .push_idx_i (pick),
      .pop_i      (commit_go[t]),
      .head_next_i(link_q[head_w[t]]),
      .head_o     (head_w[t]),
      .tail_o     (tail_w[t]),
      .has_o      (has[t])
    );

    assign hd_done      = has[t] && vld_q[head_w[t]] && (&fin_q[head_w[t]]);
    assign commit_go[t] = hd_done && !exc_q[head_w[t]] && !flush_i[t];
    assign excp_o[t]    = hd_done && exc_q[head_w[t]];
    assign commit_idx_o[t*IDXW +: IDXW] = head_w[t];

    assert_commit_frees_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit_go[t] |=> !vld_q[$past(head_w[t])]);
    assert_flush_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i[t] |=> !commit_o[t] && !excp_o[t]);
  end

  assign commit_o = commit_go;

  always_comb begin
    link_we = 1'b0;
    link_at = '0;
    for (int t = 0; t < NTHR; t++) begin
      if (disp_go[t] && has[t]) begin
        link_we = 1'b1;
        link_at = tail_w[t];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      exc_q <= '0;
      for (int e = 0; e < DEPTH; e++) begin
        tid_q[e]  <= '0;
        fin_q[e]  <= '0;
        link_q[e] <= '0;
      end
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        for (int p = 0; p < NFIN; p++) begin
          if (fin_valid_i[p] && vld_q[e] &&
              fin_entry_i[p*IDXW +: IDXW] == e[IDXW-1:0] &&
              fin_slot_i[p*SLOT_W +: SLOT_W] < SLOT_W'(GRP_MAX)) begin
            fin_q[e][fin_slot_i[p*SLOT_W +: SLOT_W]] <= 1'b1;
            if (fin_exc_i[p]) exc_q[e] <= 1'b1;
          end
        end
        if (vld_q[e] && flush_i[tid_q[e]]) vld_q[e] <= 1'b0;
        for (int t = 0; t < NTHR; t++) begin
          if (commit_go[t] && head_w[t] == e[IDXW-1:0]) vld_q[e] <= 1'b0;
        end
        if (|disp_go && pick == e[IDXW-1:0]) begin
          vld_q[e] <= 1'b1;
          tid_q[e] <= disp_tid_i;
          fin_q[e] <= slot_fill(disp_cnt_i);
          exc_q[e] <= 1'b0;
        end
        if (link_we && link_at == e[IDXW-1:0]) link_q[e] <= pick;
      end
    end
  end

  assert_alloc_fills_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|disp_go) |=> vld_q[$past(pick)]);
  assert_full_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |=> (vld_q == $past(vld_q)) || (|$past(commit_go)) || (|$past(flush_i)));
  assert_empty_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> commit_o == '0 && excp_o == '0);
  assert_one_disp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(disp_go));
endmodule

// File: tb/gct_two_thread_tb.sv
module gct_two_thread_tb;
  localparam int DEPTH = 16;
  localparam int NTHR  = 2;
  localparam int NFIN  = 2;
  localparam int IDXW  = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic disp_valid_i = 1'b0;
  logic [0:0] disp_tid_i = '0;
  logic [2:0] disp_cnt_i = '0;
  logic disp_ready_o;
  logic [IDXW-1:0] disp_idx_o;
  logic [NFIN-1:0] fin_valid_i = '0;
  logic [NFIN*IDXW-1:0] fin_entry_i = '0;
  logic [NFIN*3-1:0] fin_slot_i = '0;
  logic [NFIN-1:0] fin_exc_i = '0;
  logic [NTHR-1:0] flush_i = '0;
  logic [NTHR-1:0] commit_o;
  logic [NTHR*IDXW-1:0] commit_idx_o;
  logic [NTHR-1:0] excp_o;
  logic full_o, empty_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gct_two_thread #(.DEPTH(DEPTH), .NTHR(NTHR), .NFIN(NFIN)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .disp_valid_i(disp_valid_i), .disp_tid_i(disp_tid_i), .disp_cnt_i(disp_cnt_i),
    .disp_ready_o(disp_ready_o), .disp_idx_o(disp_idx_o),
    .fin_valid_i(fin_valid_i), .fin_entry_i(fin_entry_i), .fin_slot_i(fin_slot_i),
    .fin_exc_i(fin_exc_i), .flush_i(flush_i),
    .commit_o(commit_o), .commit_idx_o(commit_idx_o), .excp_o(excp_o),
    .full_o(full_o), .empty_o(empty_o)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic step();
    @(posedge clk); #1; @(negedge clk); #1;
  endtask

  task automatic disp(input int tid, input int cnt, output int idx);
    disp_valid_i = 1'b1; disp_tid_i = tid[0:0]; disp_cnt_i = cnt[2:0];
    #1 idx = int'(disp_idx_o);
    @(posedge clk); #1 disp_valid_i = 1'b0;
    @(negedge clk); #1;
  endtask

  task automatic fin2(input bit v0, input int e0, input int s0, input bit x0,
                      input bit v1, input int e1, input int s1, input bit x1);
    fin_valid_i = {v1, v0};
    fin_entry_i = {e1[IDXW-1:0], e0[IDXW-1:0]};
    fin_slot_i  = {s1[2:0], s0[2:0]};
    fin_exc_i   = {x1, x0};
    @(posedge clk); #1 fin_valid_i = '0; fin_exc_i = '0;
    @(negedge clk); #1;
  endtask

  task automatic fin(input int e, input int s, input bit x);
    fin2(1'b1, e, s, x, 1'b0, 0, 0, 1'b0);
  endtask

  function automatic int cidx(input int t);
    return int'(commit_idx_o[t*IDXW +: IDXW]);
  endfunction

  task automatic t_reset();
    chk("R1 empty", empty_o, 1);
    chk("R1 full", full_o, 0);
    chk("R1 ready", disp_ready_o, 1);
    chk("R1 commit", commit_o, 0);
    chk("R1 excp", excp_o, 0);
  endtask

  task automatic t_basic();
    int i;
    disp(0, 2, i);
    chk("R2 first index", i, 0);
    chk("R3 not empty", empty_o, 0);
    fin(0, 0, 0);
    chk("R5 partial no commit", commit_o, 0);
    fin(0, 1, 0);
    chk("R5 commit t0", commit_o, 1);
    chk("R5 commit idx", cidx(0), 0);
    step();
    chk("R5 freed", empty_o, 1);
  endtask

  task automatic t_order();
    int a, b, c;
    disp(0, 1, a); disp(1, 1, b); disp(0, 1, c);
    chk("R2 idx a", a, 0); chk("R2 idx b", b, 1); chk("R2 idx c", c, 2);
    fin(c, 0, 0);
    chk("R6 younger waits", commit_o, 0);
    fin(b, 0, 0);
    chk("R6 other thread commits", commit_o, 2);
    chk("R6 t1 idx", cidx(1), b);
    fin(a, 0, 0);
    chk("R6 oldest commits", commit_o, 1);
    chk("R6 oldest idx", cidx(0), a);
    step();
    chk("R6 younger next", commit_o, 1);
    chk("R6 younger idx", cidx(0), c);
    step();
    chk("R6 drained", empty_o, 1);
  endtask

  task automatic t_dual();
    int a, b;
    disp(0, 3, a); disp(1, 1, b);
    fin2(1, a, 0, 0, 1, a, 1, 0);
    chk("R4 slot2 pending", commit_o, 0);
    fin2(1, a, 2, 0, 1, b, 0, 0);
    chk("R7 both commit", commit_o, 3);
    chk("R7 idx t0", cidx(0), a);
    chk("R7 idx t1", cidx(1), b);
    step();
    chk("R7 drained", empty_o, 1);
  endtask

  task automatic t_exc();
    int a, b, d;
    disp(0, 1, a); disp(1, 2, b);
    fin(a, 0, 1);
    chk("R8 excp raised", excp_o, 1);
    chk("R8 no commit", commit_o, 0);
    step(); step();
    chk("R8 excp held", excp_o, 1);
    fin(b, 0, 0);
    flush_i = 2'b01;
    disp(0, 1, d);
    flush_i = 2'b00;
    chk("R9 excp cleared", excp_o, 0);
    chk("R9 t0 dispatch blocked", disp_idx_o, 0);
    fin(b, 1, 0);
    chk("R9 t1 kept", commit_o, 2);
    chk("R9 t1 idx", cidx(1), b);
    step();
    chk("R9 all gone", empty_o, 1);
  endtask

  task automatic t_full();
    int i, x;
    for (int k = 0; k < DEPTH; k++) begin
      disp(1, 5, i);
      chk("R2 fill idx", i, k);
    end
    chk("R3 full", full_o, 1);
    chk("R3 not ready", disp_ready_o, 0);
    disp(0, 1, x);
    chk("R3 still full", full_o, 1);
    flush_i = 2'b10; step(); flush_i = 2'b00;
    chk("R3 full dispatch dropped", empty_o, 1);
    chk("R9 no t0 commit", commit_o, 0);
  endtask

  task automatic t_stray();
    int i;
    fin2(1, 0, 0, 0, 1, 3, 1, 0);
    disp(0, 2, i);
    chk("R4 idx", i, 0);
    fin(0, 1, 0);
    chk("R4 stale finish ignored", commit_o, 0);
    fin(0, 0, 0);
    chk("R4 commit after real", commit_o, 1);
    step();
    chk("R4 drained", empty_o, 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    t_reset();
    t_basic();
    t_order();
    t_dual();
    t_exc();
    t_full();
    t_stray();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule